// File: doc/BRIEF.md
# Modulo circular address generator

This block computes the next value of a DMA source or destination pointer. It adds a signed offset to the current address. A 5-bit modulo field can confine the result to an aligned circular buffer whose size is a power of two. When the field holds a nonzero value M, only the low M bits of the address take their value from the sum. The bits above them are copied from the current address. The pointer therefore wraps inside its 2^M-byte window and never carries into the upper address. When the field is zero, the block returns the ordinary full-width sum.

The datapath is combinational. A parameter can add one output register, clocked on `clk_i` and cleared by the asynchronous active-low reset `rst_ni`. A channel uses one instance for its source pointer and a second instance, with its own modulo field, for its destination pointer. The block does not check that the buffer is aligned, and it does not sequence transfers.

Top module: `modulo_addr_gen`

## Requirements
- R1: With the modulo field at 0, the next address is the 32-bit sum of the address and the sign-extended offset, modulo 2^32 (for example, 0xFFFF_FFFE + 4 = 0x0000_0002).
- R2: With a modulo field M from 1 to 31, bits M-1..0 of the next address equal bits M-1..0 of address + offset.
- R3: With a modulo field M from 1 to 31, bits 31..M of the next address equal bits 31..M of the current address.
- R4: A positive offset that carries the pointer past the top of its 2^M window makes it continue from the bottom of the same window (M=4, 0x1000_100C + 4 gives 0x1000_1000).
- R5: A negative offset that takes the pointer below the bottom of its 2^M window makes it continue from the top of the same window (M=4, 0x1000_1002 - 4 gives 0x1000_100E).
- R6: The offset is a two's-complement value of OFF_W bits (16 by default) and is sign-extended to 32 bits, so 0x8000 adds -32768.
- R7: With OUT_REG=1, next_addr_o shows the result for the inputs present at the previous rising clock edge, and it holds 0 while rst_ni is low.
- R8: With OUT_REG=0, next_addr_o follows the inputs in the same cycle, and the clock and reset have no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the optional output register |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | ADDR_W (32) | Current pointer value |
| offset_i | input | OFF_W (16) | Signed step added to the pointer |
| mod_i | input | MOD_W (5) | Modulo field: 0 gives a linear step, M gives a 2^M-byte window |
| next_addr_o | output | ADDR_W (32) | Updated pointer |

## Verification
The bench builds two instances with the default 32-bit address, 16-bit offset and 5-bit modulo field: one with OUT_REG=1 and one with OUT_REG=0. Both are compared each cycle against a model that works in integer window arithmetic. The defaults make every window size from 2 bytes to 2 GiB reachable, so the bench forces a wrap upward and a wrap downward at each modulo value from 1 to 31. At the smallest windows, the offset is larger than the window itself. The 16-bit offset also brings the extreme step -32768 within reach for the sign-extension case.

// File: rtl/modaddr_pkg.sv
package modaddr_pkg;
  localparam int unsigned ADDR_W_DEF = 32;
  localparam int unsigned OFF_W_DEF  = 16;
  localparam int unsigned MOD_W_DEF  = 5;
endpackage

// File: rtl/mod_mask_gen.sv
module mod_mask_gen #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned MOD_W  = 5
) (
  input  logic [MOD_W-1:0]  mod_i,
  output logic [ADDR_W-1:0] mask_o
);
  logic mod_off;
  assign mod_off = (mod_i == '0);

  for (genvar i = 0; i < ADDR_W; i++) begin : g_bit
    assign mask_o[i] = mod_off || (32'(i) < 32'(mod_i));
  end

  // R2
  always_comb begin
    if (!mod_off) mask_width_chk: assert ($countones(mask_o) == 32'(mod_i));
  end
endmodule

// File: rtl/addr_adder.sv
module addr_adder #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned OFF_W  = 16
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [OFF_W-1:0]  offset_i,
  output logic [ADDR_W-1:0] sum_o
);
  localparam int unsigned EXT_W = ADDR_W - OFF_W;
  logic [ADDR_W-1:0] off_ext;
  assign off_ext = {{EXT_W{offset_i[OFF_W-1]}}, offset_i};
  assign sum_o   = addr_i + off_ext;
endmodule

// File: rtl/addr_merge.sv
module addr_merge #(
  parameter int unsigned ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [ADDR_W-1:0] sum_i,
  input  logic [ADDR_W-1:0] mask_i,
  output logic [ADDR_W-1:0] next_o
);
  assign next_o = (sum_i & mask_i) | (addr_i & ~mask_i);
endmodule

// File: rtl/out_stage.sv
module out_stage #(
  parameter int unsigned W       = 32,
  parameter bit          OUT_REG = 1'b1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  if (OUT_REG) begin : g_reg
    logic [W-1:0] q_r;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q_r <= '0;
      else         q_r <= d_i;
    end
    assign q_o = q_r;
  end else begin : g_comb
    assign q_o = d_i;
  end
endmodule

// File: rtl/modulo_addr_gen.sv
module modulo_addr_gen
  import modaddr_pkg::*;
#(
  parameter int unsigned ADDR_W  = ADDR_W_DEF,
  parameter int unsigned OFF_W   = OFF_W_DEF,
  parameter int unsigned MOD_W   = MOD_W_DEF,
  parameter bit          OUT_REG = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [OFF_W-1:0]  offset_i,
  input  logic [MOD_W-1:0]  mod_i,
  output logic [ADDR_W-1:0] next_addr_o
);
  logic [ADDR_W-1:0] sum, mask, merged;

  addr_adder #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_add (
    .addr_i(addr_i), .offset_i(offset_i), .sum_o(sum)
  );

  mod_mask_gen #(.ADDR_W(ADDR_W), .MOD_W(MOD_W)) u_mask (
    .mod_i(mod_i), .mask_o(mask)
  );

  addr_merge #(.ADDR_W(ADDR_W)) u_merge (
    .addr_i(addr_i), .sum_i(sum), .mask_i(mask), .next_o(merged)
  );

  out_stage #(.W(ADDR_W), .OUT_REG(OUT_REG)) u_out (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(merged), .q_o(next_addr_o)
  );

  // R1
  linear_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mod_i == '0) |-> (merged == sum));

  // R3
  upper_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mod_i != '0) |-> (((merged ^ addr_i) >> mod_i) == '0));

  // R2
  low_take_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mod_i != '0) |-> (((merged ^ sum) << (32'(ADDR_W) - 32'(mod_i))) == '0));

  if (OUT_REG) begin : g_reg_chk
    // R7
    reg_delay_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rst_ni |=> (next_addr_o == $past(merged)));
  end else begin : g_comb_chk
    // R8
    comb_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      next_addr_o == merged);
  end
endmodule

// File: tb/modulo_addr_gen_tb_top.sv
module modulo_addr_gen_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] addr = '0;
  logic [15:0] off = '0;
  logic [4:0]  mod = '0;
  logic [31:0] q_reg, q_comb;
  int n_vec = 0, n_bad = 0;

  always #5 clk = ~clk;

  modulo_addr_gen #(.OUT_REG(1'b1)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .offset_i(off), .mod_i(mod),
    .next_addr_o(q_reg)
  );
  modulo_addr_gen #(.OUT_REG(1'b0)) dut_comb_i (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .offset_i(off), .mod_i(mod),
    .next_addr_o(q_comb)
  );

  function automatic logic [31:0] ref_next(logic [31:0] a, logic signed [15:0] o, int m);
    longint av, w, base, lo, s;
    av = longint'({32'h0, a});
    s  = av + longint'(o);
    if (m == 0) return s[31:0];
    w    = longint'(1) << m;
    base = av - (av % w);
    lo   = ((av % w) + longint'(o)) % w;
    if (lo < 0) lo = lo + w;
    s = base + lo;
    return s[31:0];
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic apply(logic [31:0] a, logic [15:0] o, int m, string req);
    logic [31:0] e;
    @(negedge clk);
    addr = a; off = o; mod = m[4:0];
    e = ref_next(a, o, m);
    #1 check({req, " comb R8"}, q_comb, e);
    @(posedge clk);
    #1 check({req, " reg R7"}, q_reg, e);
  endtask

  initial begin
    #200000000;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] lfsr;
    lfsr = 32'hACE1_2345;
    addr = 32'h1234_5678; off = 16'h0010; mod = 5'd3;
    repeat (3) @(posedge clk);
    #1 check("R7 reset", q_reg, 32'h0);
    check("R8 reset", q_comb, ref_next(32'h1234_5678, 16'h0010, 3));
    @(negedge clk);
    rst_n = 1'b1;

    apply(32'hFFFF_FFFE, 16'h0004, 0, "R1 carry out");
    apply(32'h0000_0010, 16'hFFE0, 0, "R1 borrow");
    apply(32'h1000_100C, 16'h0004, 4, "R4 m4 up");
    apply(32'h1000_1002, 16'hFFFC, 4, "R5 m4 down");
    apply(32'h0000_0000, 16'h8000, 0, "R6 min offset");
    apply(32'h0001_0000, 16'h8000, 20, "R6 min offset mod");
    apply(32'h0000_0000, 16'h7FFF, 0, "R6 max offset");

    for (int m = 1; m < 32; m++) begin
      logic [31:0] top, w;
      w   = 32'h1 << m;
      top = (32'hA5A5_A5A5 & ~(w - 1)) | (w - 32'd4);
      apply(top, 16'h0008, m, "R4 R2 R3 up");
      apply((32'h5A5A_5A5A & ~(w - 1)) | (32'd2 & (w - 1)), 16'hFFFA, m, "R5 R2 R3 down");
      apply(32'hFFFF_FFFF, 16'h0001, m, "R3 all ones");
    end

    for (int i = 0; i < 400; i++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      apply(lfsr ^ 32'h9E37_79B9, lfsr[15:0] ^ lfsr[31:16], int'(lfsr[4:0] ^ lfsr[12:8]),
            "R1 R2 R3 mix");
    end

    @(negedge clk);
    rst_n = 1'b0;
    #1 check("R7 async reset", q_reg, 32'h0);
    check("R8 under reset", q_comb, ref_next(addr, off, int'(mod)));

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule